// File: doc/BRIEF.md
# RV32 Compressed Instruction Decoder

This block sits between instruction fetch and the main decode stage of an RV32 core. It looks at one fetched 32-bit word, decides from its two lowest bits whether the word holds a 16-bit compressed instruction or a full-width base instruction, and tells the program-counter logic how many bytes to step past it. The block is purely combinational. Every output settles from the input word in the same cycle.

For compressed words in quadrants 0, 1 and 2 of the integer subset, the block names the operation with a small class code. It expands the 3-bit short register fields into full indices and fills in the implied stack-pointer and link registers. It also rebuilds the scattered immediate bits of each format into one 32-bit value, which is sign- or zero-extended as the format requires. The covered operations are stack-relative and register-relative word loads and stores, immediate add, load-immediate, stack adjustment, shift-left, jumps, compare-with-zero branches, register move and jump-register. Any other compressed encoding raises an illegal flag, and all the other decode outputs are then forced to zero. Base words pass through with a class code that hands them to the full-width decoder.

Top module: `cdec_top`

## Requirements
- R1: When bits [1:0] of `instr` are not 2'b11, `isCompressed` is 1 and `stepBytes` is 2. When they are 2'b11, `isCompressed` is 0, `stepBytes` is 4, `opClass` is 1 (base), `illegal` is 0, and the register indices and `imm` are 0.
- R2: The class codes on `opClass` are 0 illegal, 1 base, 2 stack-address-add (q0 f3 000), 3 word load (q0 010), 4 word store (q0 110), 5 add-immediate (q1 000), 6 jump-and-link (q1 001), 7 load-immediate (q1 010), 8 stack adjust (q1 011), 9 jump (q1 101), 10 branch-if-zero (q1 110), 11 branch-if-nonzero (q1 111), 12 shift-left (q2 000), 13 stack load (q2 010), 14 jump-register, 15 move, 16 stack store (q2 110). Here the quadrant is `instr[1:0]` and f3 is `instr[15:13]`.
- R3: In q2 with f3 100 and bit 12 clear, bits [6:2] equal to zero give class 14, with `rs1Idx` = bits [11:7] and `rdIdx` = 0. Any other value gives class 15, with `rdIdx` = bits [11:7], `rs2Idx` = bits [6:2] and `rs1Idx` = 0.
- R4: A short register field (bits [9:7] as base, bits [4:2] as destination or data) maps to index 8 plus the field value. This applies to classes 2, 3, 4, 10 and 11. Branches drive `rs2Idx` = 0.
- R5: Classes 2, 8, 13 and 16 use index 2 as `rs1Idx`, and class 8 also writes `rdIdx` = 2. Class 6 writes `rdIdx` = 1 and class 9 writes `rdIdx` = 0.
- R6: For class 2, `imm` is zero-extended with imm[9:6]=bits[10:7], imm[5:4]=bits[12:11], imm[3]=bit 5 and imm[2]=bit 6.
- R7: For classes 5 and 7, `imm` is {bit 12, bits[6:2]} sign-extended from bit 12. For class 12, `imm` is bits [6:2] zero-extended. Classes 5 and 12 use bits [11:7] as both `rdIdx` and `rs1Idx`. Class 7 uses them as `rdIdx`, with `rs1Idx` = 0.
- R8: For class 8, `imm` is sign-extended from bit 12, with imm[9]=bit 12, imm[8:7]=bits[4:3], imm[6]=bit 5, imm[5]=bit 2 and imm[4]=bit 6. All lower bits are zero.
- R9: Offsets are zero-extended. For class 13, imm[7:6]=bits[3:2], imm[5]=bit 12 and imm[4:2]=bits[6:4], and `rdIdx` = bits [11:7]. For class 16, imm[7:6]=bits[8:7] and imm[5:2]=bits[12:9], and `rs2Idx` = bits [6:2].
- R10: For classes 3 and 4, `imm` is zero-extended with imm[6]=bit 5, imm[5:3]=bits[12:10] and imm[2]=bit 6.
- R11: For classes 10 and 11, `imm` is sign-extended from bit 12, with imm[8]=bit 12, imm[7:6]=bits[6:5], imm[5]=bit 2, imm[4:3]=bits[11:10], imm[2:1]=bits[4:3] and imm[0]=0.
- R12: For classes 6 and 9, `imm` is sign-extended from bit 12, with imm[11]=bit 12, imm[10]=bit 8, imm[9:8]=bits[10:9], imm[7]=bit 6, imm[6]=bit 7, imm[5]=bit 2, imm[4]=bit 11, imm[3:1]=bits[5:3] and imm[0]=0.
- R13: These compressed words are illegal: any f3 slot not named in R2 (q0 001, 011, 100, 101, 111; q1 100; q2 001, 011, 101, 111), a q0 f3 000 word with bits [12:5] all zero (this includes the all-zero word), a q1 f3 011 word whose bits [11:7] are not 2, a q2 f3 000 word with bit 12 set, and a q2 f3 100 word with bit 12 set. For these words `illegal` is 1, and `opClass`, the three register indices and `imm` are 0, while `isCompressed` is 1 and `stepBytes` is 2.
- R14: Bits [31:16] have no effect on any output of a compressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Fetched instruction word |
| isCompressed | output | 1 | Word holds a 16-bit instruction in its low half |
| stepBytes | output | 3 | Bytes to advance the program counter (2 or 4) |
| opClass | output | 5 | Operation class code |
| rdIdx | output | 5 | Destination register index |
| rs1Idx | output | 5 | First source register index |
| rs2Idx | output | 5 | Second source register index |
| imm | output | 32 | Reassembled, extended immediate |
| illegal | output | 1 | Unsupported or reserved compressed encoding |

## Verification
The checker checks several relations on every change of the input word. It ties the step size to the compressed flag. It checks that illegal and base words leave all decode outputs at zero. It checks that the short-register classes always land in the x8 to x15 window and that the stack classes always address x2. It also checks the alignment and extension shape of each immediate class, such as even branch and jump offsets, word-aligned stack offsets, and an upper half that copies the sign bit. Only the bench's directed scenarios can show the actual bit placement of each scrambled immediate, the exact class chosen for each slot, the move/jump-register split and the full list of rejected encodings. Each of these needs a known word paired with a value worked out by hand.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

  localparam int REG_W   = 5;
  localparam int CLASS_W = 5;
  localparam int HALF_W  = 16;

  typedef enum logic [CLASS_W-1:0] {
    OPC_ILLEGAL  = 5'd0,
    OPC_BASE     = 5'd1,
    OPC_ADDSP4   = 5'd2,
    OPC_LOADW    = 5'd3,
    OPC_STOREW   = 5'd4,
    OPC_ADDIMM   = 5'd5,
    OPC_JUMPLINK = 5'd6,
    OPC_LOADIMM  = 5'd7,
    OPC_ADDSP16  = 5'd8,
    OPC_JUMP     = 5'd9,
    OPC_BREQZ    = 5'd10,
    OPC_BRNEZ    = 5'd11,
    OPC_SHIFTL   = 5'd12,
    OPC_LOADSP   = 5'd13,
    OPC_JUMPREG  = 5'd14,
    OPC_MOVE     = 5'd15,
    OPC_STORESP  = 5'd16
  } opClass_e;

  // Immediate layouts the datapath knows how to reassemble
  typedef enum logic [3:0] {
    IMM_ZERO,
    IMM_SPN,
    IMM_CI,
    IMM_SP16,
    IMM_LDSP,
    IMM_STSP,
    IMM_MEMW,
    IMM_BRANCH,
    IMM_JUMP,
    IMM_SHAMT
  } immFmt_e;

  // Register index sources
  typedef enum logic [2:0] {
    REG_ZERO,
    REG_SP,
    REG_RA,
    REG_HI5,
    REG_LO5,
    REG_PHI,
    REG_PLO
  } regSel_e;

  typedef struct packed {
    immFmt_e immFmt;
    regSel_e rdSel;
    regSel_e rs1Sel;
    regSel_e rs2Sel;
  } decStrobe_t;

  localparam int SP_IDX     = 2;
  localparam int RA_IDX     = 1;
  localparam int PRIME_BASE = 8;

endpackage

// File: rtl/cdec_ctrl.sv
module cdec_ctrl
  import cdec_pkg::*;
(
  input  logic [HALF_W-1:0] half,
  output logic              isComp,
  output logic [2:0]        step,
  output opClass_e          opClass,
  output logic              illegal,
  output decStrobe_t        strobe
);

  localparam decStrobe_t NULL_STROBE = '{IMM_ZERO, REG_ZERO, REG_ZERO, REG_ZERO};

  logic [1:0] quad;
  logic [2:0] funct;
  logic       bit12;
  logic       hiIsSp;
  logic       loIsZero;
  logic       spnZero;

  assign quad     = half[1:0];
  assign funct    = half[15:13];
  assign bit12    = half[12];
  assign hiIsSp   = (half[11:7] == 5'(SP_IDX));
  assign loIsZero = (half[6:2] == '0);
  assign spnZero  = (half[12:5] == '0);

  assign isComp = (quad != 2'b11);
  assign step   = isComp ? 3'd2 : 3'd4;

  function automatic decStrobe_t mk(immFmt_e f, regSel_e d, regSel_e a, regSel_e b);
    decStrobe_t s;
    s.immFmt = f;
    s.rdSel  = d;
    s.rs1Sel = a;
    s.rs2Sel = b;
    return s;
  endfunction

  always_comb begin
    opClass = OPC_ILLEGAL;
    illegal = 1'b1;
    strobe  = NULL_STROBE;
    unique case (quad)
      2'b11: begin
        opClass = OPC_BASE;
        illegal = 1'b0;
      end
      2'b00: begin
        unique case (funct)
          3'b000: if (!spnZero) begin
            opClass = OPC_ADDSP4;
            strobe  = mk(IMM_SPN, REG_PLO, REG_SP, REG_ZERO);
          end
          3'b010: begin
            opClass = OPC_LOADW;
            strobe  = mk(IMM_MEMW, REG_PLO, REG_PHI, REG_ZERO);
          end
          3'b110: begin
            opClass = OPC_STOREW;
            strobe  = mk(IMM_MEMW, REG_ZERO, REG_PHI, REG_PLO);
          end
          default: ;
        endcase
      end
      2'b01: begin
        unique case (funct)
          3'b000: begin
            opClass = OPC_ADDIMM;
            strobe  = mk(IMM_CI, REG_HI5, REG_HI5, REG_ZERO);
          end
          3'b001: begin
            opClass = OPC_JUMPLINK;
            strobe  = mk(IMM_JUMP, REG_RA, REG_ZERO, REG_ZERO);
          end
          3'b010: begin
            opClass = OPC_LOADIMM;
            strobe  = mk(IMM_CI, REG_HI5, REG_ZERO, REG_ZERO);
          end
          3'b011: if (hiIsSp) begin
            opClass = OPC_ADDSP16;
            strobe  = mk(IMM_SP16, REG_SP, REG_SP, REG_ZERO);
          end
          3'b101: begin
            opClass = OPC_JUMP;
            strobe  = mk(IMM_JUMP, REG_ZERO, REG_ZERO, REG_ZERO);
          end
          3'b110: begin
            opClass = OPC_BREQZ;
            strobe  = mk(IMM_BRANCH, REG_ZERO, REG_PHI, REG_ZERO);
          end
          3'b111: begin
            opClass = OPC_BRNEZ;
            strobe  = mk(IMM_BRANCH, REG_ZERO, REG_PHI, REG_ZERO);
          end
          default: ;
        endcase
      end
      default: begin
        unique case (funct)
          3'b000: if (!bit12) begin
            opClass = OPC_SHIFTL;
            strobe  = mk(IMM_SHAMT, REG_HI5, REG_HI5, REG_ZERO);
          end
          3'b010: begin
            opClass = OPC_LOADSP;
            strobe  = mk(IMM_LDSP, REG_HI5, REG_SP, REG_ZERO);
          end
          3'b100: if (!bit12) begin
            if (loIsZero) begin
              opClass = OPC_JUMPREG;
              strobe  = mk(IMM_ZERO, REG_ZERO, REG_HI5, REG_ZERO);
            end else begin
              opClass = OPC_MOVE;
              strobe  = mk(IMM_ZERO, REG_HI5, REG_ZERO, REG_LO5);
            end
          end
          3'b110: begin
            opClass = OPC_STORESP;
            strobe  = mk(IMM_STSP, REG_ZERO, REG_SP, REG_LO5);
          end
          default: ;
        endcase
      end
    endcase
    if (opClass != OPC_ILLEGAL) illegal = 1'b0;
  end

endmodule

// File: rtl/cdec_datapath.sv
module cdec_datapath
  import cdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [12:2]      body,
  input  decStrobe_t       strobe,
  output logic [XLEN-1:0]  imm,
  output logic [REG_W-1:0] rdIdx,
  output logic [REG_W-1:0] rs1Idx,
  output logic [REG_W-1:0] rs2Idx
);

  localparam int NPORT = 3;

  // Reassembled raw immediates, at their natural widths
  logic [9:0]  spnRaw;
  logic [5:0]  ciRaw;
  logic [9:0]  sp16Raw;
  logic [7:0]  ldspRaw;
  logic [7:0]  stspRaw;
  logic [6:0]  memwRaw;
  logic [8:0]  brRaw;
  logic [11:0] jmpRaw;
  logic [4:0]  shRaw;

  assign spnRaw  = {body[10:7], body[12:11], body[5], body[6], 2'b00};
  assign ciRaw   = {body[12], body[6:2]};
  assign sp16Raw = {body[12], body[4:3], body[5], body[2], body[6], 4'b0000};
  assign ldspRaw = {body[3:2], body[12], body[6:4], 2'b00};
  assign stspRaw = {body[8:7], body[12:9], 2'b00};
  assign memwRaw = {body[5], body[12:10], body[6], 2'b00};
  assign brRaw   = {body[12], body[6:5], body[2], body[11:10], body[4:3], 1'b0};
  assign jmpRaw  = {body[12], body[8], body[10:9], body[6], body[7], body[2],
                    body[11], body[5:3], 1'b0};
  assign shRaw   = body[6:2];

  always_comb begin
    unique case (strobe.immFmt)
      IMM_SPN:    imm = {{(XLEN-10){1'b0}}, spnRaw};
      IMM_CI:     imm = {{(XLEN-6){ciRaw[5]}}, ciRaw};
      IMM_SP16:   imm = {{(XLEN-10){sp16Raw[9]}}, sp16Raw};
      IMM_LDSP:   imm = {{(XLEN-8){1'b0}}, ldspRaw};
      IMM_STSP:   imm = {{(XLEN-8){1'b0}}, stspRaw};
      IMM_MEMW:   imm = {{(XLEN-7){1'b0}}, memwRaw};
      IMM_BRANCH: imm = {{(XLEN-9){brRaw[8]}}, brRaw};
      IMM_JUMP:   imm = {{(XLEN-12){jmpRaw[11]}}, jmpRaw};
      IMM_SHAMT:  imm = {{(XLEN-5){1'b0}}, shRaw};
      default:    imm = '0;
    endcase
  end

  regSel_e          selArr [NPORT];
  logic [REG_W-1:0] idxArr [NPORT];

  assign selArr[0] = strobe.rdSel;
  assign selArr[1] = strobe.rs1Sel;
  assign selArr[2] = strobe.rs2Sel;

  for (genvar g = 0; g < NPORT; g++) begin : g_regPort
    always_comb begin
      unique case (selArr[g])
        REG_SP:  idxArr[g] = REG_W'(SP_IDX);
        REG_RA:  idxArr[g] = REG_W'(RA_IDX);
        REG_HI5: idxArr[g] = body[11:7];
        REG_LO5: idxArr[g] = body[6:2];
        REG_PHI: idxArr[g] = REG_W'(PRIME_BASE) | REG_W'(body[9:7]);
        REG_PLO: idxArr[g] = REG_W'(PRIME_BASE) | REG_W'(body[4:2]);
        default: idxArr[g] = '0;
      endcase
    end
  end

  assign rdIdx  = idxArr[0];
  assign rs1Idx = idxArr[1];
  assign rs2Idx = idxArr[2];

endmodule

// File: rtl/cdec_top.sv
module cdec_top
  import cdec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0]    instr,
  output logic               isCompressed,
  output logic [2:0]         stepBytes,
  output logic [CLASS_W-1:0] opClass,
  output logic [REG_W-1:0]   rdIdx,
  output logic [REG_W-1:0]   rs1Idx,
  output logic [REG_W-1:0]   rs2Idx,
  output logic [XLEN-1:0]    imm,
  output logic               illegal
);

  decStrobe_t strobe;
  opClass_e   cls;
  logic       unusedHi;

  // Upper half never steers the compressed decode
  assign unusedHi = ^instr[ILEN-1:HALF_W];

  cdec_ctrl i_ctrl (
    .half    (instr[HALF_W-1:0]),
    .isComp  (isCompressed),
    .step    (stepBytes),
    .opClass (cls),
    .illegal (illegal),
    .strobe  (strobe)
  );

  cdec_datapath #(.XLEN(XLEN)) i_dp (
    .body   (instr[12:2]),
    .strobe (strobe),
    .imm    (imm),
    .rdIdx  (rdIdx),
    .rs1Idx (rs1Idx),
    .rs2Idx (rs2Idx)
  );

  assign opClass = cls;

endmodule

// File: rtl/cdec_checker.sv
module cdec_checker (
  input logic [31:0] instr,
  input logic        isCompressed,
  input logic [2:0]  stepBytes,
  input logic [4:0]  opClass,
  input logic [4:0]  rdIdx,
  input logic [4:0]  rs1Idx,
  input logic [4:0]  rs2Idx,
  input logic [31:0] imm,
  input logic        illegal
);

  always_comb begin
    if (!$isunknown(instr)) begin
      // R1
      step_len_chk: assert (stepBytes == (isCompressed ? 3'd2 : 3'd4))
        else $error("step size does not match compressed flag");
      // R1
      base_pass_chk: assert (isCompressed || (opClass == 5'd1 && !illegal && imm == '0
                                              && rdIdx == '0 && rs1Idx == '0 && rs2Idx == '0))
        else $error("base word not passed through cleanly");
      // R13
      illegal_quiet_chk: assert (!illegal || (opClass == '0 && imm == '0 && rdIdx == '0
                                              && rs1Idx == '0 && rs2Idx == '0 && isCompressed))
        else $error("illegal word left outputs active");
      // R4
      prime_window_chk: assert (!(opClass inside {5'd2, 5'd3, 5'd4, 5'd10, 5'd11})
                                || rs1Idx[4:3] == 2'b01 || rs1Idx == 5'd2)
        else $error("short register field outside x8..x15");
      // R5
      stack_base_chk: assert (!(opClass inside {5'd2, 5'd8, 5'd13, 5'd16}) || rs1Idx == 5'd2)
        else $error("stack class not based on x2");
      // R11
      branch_shape_chk: assert (!(opClass inside {5'd10, 5'd11})
                                || (imm[0] == 1'b0 && (&imm[31:8] || ~|imm[31:8])))
        else $error("branch offset shape wrong");
      // R12
      jump_shape_chk: assert (!(opClass inside {5'd6, 5'd9})
                              || (imm[0] == 1'b0 && (&imm[31:11] || ~|imm[31:11])))
        else $error("jump offset shape wrong");
      // R9
      stack_off_chk: assert (!(opClass inside {5'd13, 5'd16})
                             || (imm[1:0] == 2'b00 && imm[31:8] == '0))
        else $error("stack offset not a small aligned word offset");
    end
  end

endmodule

bind cdec_top cdec_checker i_cdec_checker (
  .instr        (instr),
  .isCompressed (isCompressed),
  .stepBytes    (stepBytes),
  .opClass      (opClass),
  .rdIdx        (rdIdx),
  .rs1Idx       (rs1Idx),
  .rs2Idx       (rs2Idx),
  .imm          (imm),
  .illegal      (illegal)
);

// File: tb/test_cdec_top.sv
module test_cdec_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic        isCompressed;
  logic [2:0]  stepBytes;
  logic [4:0]  opClass;
  logic [4:0]  rdIdx;
  logic [4:0]  rs1Idx;
  logic [4:0]  rs2Idx;
  logic [31:0] imm;
  logic        illegal;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cdec_top i_cdec_top (
    .instr        (instr),
    .isCompressed (isCompressed),
    .stepBytes    (stepBytes),
    .opClass      (opClass),
    .rdIdx        (rdIdx),
    .rs1Idx       (rs1Idx),
    .rs2Idx       (rs2Idx),
    .imm          (imm),
    .illegal      (illegal)
  );

  // ---- encoders: place immediate bits into compressed words ----
  function automatic logic [15:0] encSpn(logic [9:0] v, logic [2:0] rdp);
    return {3'b000, v[5:4], v[9:6], v[2], v[3], rdp, 2'b00};
  endfunction
  function automatic logic [15:0] encCi(logic [2:0] f, logic [1:0] q, logic [4:0] rd, logic [5:0] v);
    return {f, v[5], rd, v[4:0], q};
  endfunction
  function automatic logic [15:0] encSp16(logic [9:0] v);
    return {3'b011, v[9], 5'd2, v[4], v[6], v[8:7], v[5], 2'b01};
  endfunction
  function automatic logic [15:0] encLdsp(logic [4:0] rd, logic [7:0] v);
    return {3'b010, v[5], rd, v[4:2], v[7:6], 2'b10};
  endfunction
  function automatic logic [15:0] encStsp(logic [4:0] rs2, logic [7:0] v);
    return {3'b110, v[5:2], v[7:6], rs2, 2'b10};
  endfunction
  function automatic logic [15:0] encMem(logic [2:0] f, logic [2:0] bp, logic [2:0] rp, logic [6:0] v);
    return {f, v[5:3], bp, v[2], v[6], rp, 2'b00};
  endfunction
  function automatic logic [15:0] encBr(logic [2:0] f, logic [2:0] bp, logic [8:0] v);
    return {f, v[8], v[4:3], bp, v[7:6], v[2:1], v[5], 2'b01};
  endfunction
  function automatic logic [15:0] encJmp(logic [2:0] f, logic [11:0] v);
    return {f, v[11], v[4], v[9:8], v[10], v[6], v[7], v[3:1], v[5], 2'b01};
  endfunction

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    instr = w;
    @(posedge clk);
    #1;
  endtask

  task automatic expectAll(string req, logic comp, logic [4:0] cls, logic [4:0] rd,
                           logic [4:0] r1, logic [4:0] r2, logic [31:0] im, logic ill);
    logic [2:0] st;
    st = comp ? 3'd2 : 3'd4;
    checks++;
    if (isCompressed !== comp || stepBytes !== st || opClass !== cls || rdIdx !== rd ||
        rs1Idx !== r1 || rs2Idx !== r2 || imm !== im || illegal !== ill) begin
      fails++;
      $display("FAIL %s instr=%h actual comp=%b step=%0d cls=%0d rd=%0d rs1=%0d rs2=%0d imm=%h ill=%b expected comp=%b step=%0d cls=%0d rd=%0d rs1=%0d rs2=%0d imm=%h ill=%b",
               req, instr, isCompressed, stepBytes, opClass, rdIdx, rs1Idx, rs2Idx, imm, illegal,
               comp, st, cls, rd, r1, r2, im, ill);
    end
  endtask

  task automatic tResetWord;
    // R13: zero word present from reset is illegal
    expectAll("R13 reset zero word", 1, 0, 0, 0, 0, 32'h0, 1);
  endtask

  task automatic tLength;
    apply(32'h0050_0093);
    expectAll("R1 base word", 0, 1, 0, 0, 0, 32'h0, 0);
    apply(32'hFFFF_FFFF);
    expectAll("R1 base all ones", 0, 1, 0, 0, 0, 32'h0, 0);
  endtask

  task automatic tQuad0;
    apply({16'hA5A5, encSpn(10'h3FC, 3'd3)});
    expectAll("R6 R14 stack-address-add max", 1, 2, 11, 2, 0, 32'd1020, 0);
    apply({16'h0000, encSpn(10'd4, 3'd0)});
    expectAll("R6 R4 stack-address-add small", 1, 2, 8, 2, 0, 32'd4, 0);
    apply({16'h1234, encMem(3'b010, 3'd1, 3'd7, 7'd124)});
    expectAll("R10 R4 word load", 1, 3, 15, 9, 0, 32'd124, 0);
    apply({16'h0000, encMem(3'b110, 3'd5, 3'd2, 7'd64)});
    expectAll("R10 R4 word store", 1, 4, 0, 13, 10, 32'd64, 0);
  endtask

  task automatic tQuad1Arith;
    apply({16'h0000, encCi(3'b000, 2'b01, 5'd5, 6'b100000)});
    expectAll("R7 add-immediate negative", 1, 5, 5, 5, 0, 32'hFFFF_FFE0, 0);
    apply({16'hFFFF, encCi(3'b000, 2'b01, 5'd31, 6'd31)});
    expectAll("R7 R14 add-immediate positive", 1, 5, 31, 31, 0, 32'd31, 0);
    apply({16'h0000, encCi(3'b010, 2'b01, 5'd10, 6'h3F)});
    expectAll("R7 load-immediate", 1, 7, 10, 0, 0, 32'hFFFF_FFFF, 0);
    apply({16'h0000, encSp16(10'h200)});
    expectAll("R8 R5 stack adjust negative", 1, 8, 2, 2, 0, 32'hFFFF_FE00, 0);
    apply({16'h0000, encSp16(10'h1F0)});
    expectAll("R8 stack adjust positive", 1, 8, 2, 2, 0, 32'd496, 0);
  endtask

  task automatic tJumps;
    apply({16'h0000, encJmp(3'b001, 12'h800)});
    expectAll("R12 R5 jump-and-link", 1, 6, 1, 0, 0, 32'hFFFF_F800, 0);
    apply({16'h0000, encJmp(3'b101, 12'h7FE)});
    expectAll("R12 R5 jump forward", 1, 9, 0, 0, 0, 32'd2046, 0);
    apply({16'h0000, encJmp(3'b101, 12'hFFE)});
    expectAll("R12 jump back", 1, 9, 0, 0, 0, 32'hFFFF_FFFE, 0);
    apply({16'h0000, encJmp(3'b101, 12'h556)});
    expectAll("R12 jump pattern", 1, 9, 0, 0, 0, 32'h0000_0556, 0);
  endtask

  task automatic tBranches;
    apply({16'h0000, encBr(3'b110, 3'd4, 9'h100)});
    expectAll("R11 R4 branch-if-zero", 1, 10, 0, 12, 0, 32'hFFFF_FF00, 0);
    apply({16'h0000, encBr(3'b111, 3'd0, 9'd254)});
    expectAll("R11 R4 branch-if-nonzero", 1, 11, 0, 8, 0, 32'd254, 0);
    apply({16'h0000, encBr(3'b111, 3'd7, 9'h0AA)});
    expectAll("R11 branch pattern", 1, 11, 0, 15, 0, 32'h0000_00AA, 0);
  endtask

  task automatic tQuad2;
    apply({16'h0000, encCi(3'b000, 2'b10, 5'd7, 6'd31)});
    expectAll("R7 shift-left", 1, 12, 7, 7, 0, 32'd31, 0);
    apply({16'h0000, encLdsp(5'd1, 8'd252)});
    expectAll("R9 R5 stack load", 1, 13, 1, 2, 0, 32'd252, 0);
    apply({16'h0000, encLdsp(5'd9, 8'h64)});
    expectAll("R9 stack load pattern", 1, 13, 9, 2, 0, 32'h64, 0);
    apply({16'h0000, encStsp(5'd31, 8'd252)});
    expectAll("R9 R5 stack store", 1, 16, 0, 2, 31, 32'd252, 0);
    apply({16'h0000, encStsp(5'd6, 8'h94)});
    expectAll("R9 stack store pattern", 1, 16, 0, 2, 6, 32'h94, 0);
  endtask

  task automatic tJrMv;
    apply({16'h0000, 3'b100, 1'b0, 5'd1, 5'd0, 2'b10});
    expectAll("R3 jump-register", 1, 14, 0, 1, 0, 32'h0, 0);
    apply({16'h0000, 3'b100, 1'b0, 5'd3, 5'd4, 2'b10});
    expectAll("R3 move", 1, 15, 3, 0, 4, 32'h0, 0);
    apply({16'h0000, 3'b100, 1'b0, 5'd0, 5'd1, 2'b10});
    expectAll("R3 move lowest source", 1, 15, 0, 0, 1, 32'h0, 0);
  endtask

  task automatic tIllegal;
    apply(32'h0000_0000);
    expectAll("R13 all-zero word", 1, 0, 0, 0, 0, 32'h0, 1);
    apply({16'hFFFF, 3'b000, 8'h00, 3'd5, 2'b00});
    expectAll("R13 R14 zero stack-add imm", 1, 0, 0, 0, 0, 32'h0, 1);
    apply({16'h0000, 16'h2000});
    expectAll("R13 q0 f3 001", 1, 0, 0, 0, 0, 32'h0, 1);
    apply({16'h0000, 16'hE3FC});
    expectAll("R13 q0 f3 111", 1, 0, 0, 0, 0, 32'h0, 1);
    apply({16'h0000, 16'h8001});
    expectAll("R13 q1 f3 100", 1, 0, 0, 0, 0, 32'h0, 1);
    apply({16'h0000, 16'hE002});
    expectAll("R13 q2 f3 111", 1, 0, 0, 0, 0, 32'h0, 1);
    apply({16'h0000, 16'h3002});
    expectAll("R13 q2 f3 001", 1, 0, 0, 0, 0, 32'h0, 1);
    apply({16'h0000, encCi(3'b011, 2'b01, 5'd3, 6'd1)});
    expectAll("R13 stack adjust slot other reg", 1, 0, 0, 0, 0, 32'h0, 1);
    apply({16'h0000, encCi(3'b000, 2'b10, 5'd5, 6'b100001)});
    expectAll("R13 shift-left bit12", 1, 0, 0, 0, 0, 32'h0, 1);
    apply({16'h0000, 3'b100, 1'b1, 5'd3, 5'd4, 2'b10});
    expectAll("R13 q2 f3 100 bit12", 1, 0, 0, 0, 0, 32'h0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #1;
    tResetWord();
    tLength();
    tQuad0();
    tQuad1Arith();
    tJumps();
    tBranches();
    tQuad2();
    tJrMv();
    tIllegal();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule